// File: doc/BRIEF.md
# Flag Offset Register Programming Unit

This unit holds the two threshold offsets used by a FIFO's flag logic: the almost-empty offset and the almost-full offset. A master reset loads both offsets with one of two default values. The level of the configuration select input during that reset picks the default. The same level also fixes, until the next master reset, how software may later change the offsets: a bit at a time through a serial pin, or a whole word at a time over the data input bus.

Once master reset is released, the configuration select input takes a second role. While it is high, write-enabled clock edges go to the offset registers instead of the data memory, and read-enabled clock edges drive the offset registers onto the output bus. The serial input pin is also shared. During master reset it supplies a fall-through mode bit, which this unit latches. After reset it carries serial offset data.

A partial reset restarts the load and read-back sequences and clears the output bus. It keeps the offsets, the programming method and the latched mode bit. Flag comparison and data storage sit outside this unit. The unit's outputs are the two offsets.

Top module: `fofs_prog`

## Requirements
- R1: During master reset (`rst`=1), `cfg_sel`=1 loads both offsets with DEF_HI (1023) and `cfg_sel`=0 loads both with DEF_LO (127). The values are visible after that clock edge.
- R2: The `cfg_sel` level sampled during master reset is held on `ser_mode`: 1 selects serial programming and 0 selects parallel programming.
- R3: The `ser_in` level sampled during master reset is held on `ft_mode`. Changes on `ser_in` after reset do not alter `ft_mode`.
- R4: In parallel mode, each edge with `cfg_sel`=1 and `wr_en`=1 writes `din` into the next offset in the order empty, full, empty, and so on. If any bit of `din` above bit OFS_W-1 is set, the written value saturates to all ones.
- R5: A write edge with `cfg_sel`=0 leaves both offsets unchanged.
- R6: In serial mode, each edge with `ser_en`=1 stores `ser_in` into the next offset bit. The order is empty offset bits 0 to OFS_W-1, then full offset bits 0 to OFS_W-1, so one complete load takes 2*OFS_W edges before the sequence wraps.
- R7: Parallel writes have no effect in serial mode, and `ser_en` has no effect in parallel mode.
- R8: An edge with `cfg_sel`=1 and `rd_en`=1 drives the next offset onto `dout`, zero-extended, with the empty offset first and then the full offset. Reads keep a sequence position separate from writes. `dout` keeps its value on every other edge.
- R9: Partial reset (`prst`=1) keeps both offsets, `ser_mode` and `ft_mode`, clears `dout` to zero, and returns the write, read and serial sequences to their first position.
- R10: Master reset clears `dout` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| prst | input | 1 | Synchronous active-high partial reset |
| cfg_sel | input | 1 | Default/method select during reset; offset register steering afterwards |
| ser_in | input | 1 | Mode bit during reset; serial offset data afterwards |
| ser_en | input | 1 | Serial shift enable |
| wr_en | input | 1 | Write enable |
| rd_en | input | 1 | Read enable |
| din | input | BUS_W | Data input bus |
| dout | output | BUS_W | Offset read-back bus (registered) |
| empty_ofs | output | OFS_W | Current almost-empty offset |
| full_ofs | output | OFS_W | Current almost-full offset |
| ser_mode | output | 1 | 1 when serial programming was selected |
| ft_mode | output | 1 | Fall-through mode bit latched at master reset |

## Verification
Every output of this unit is registered. The effect of a stimulus sampled at one rising edge therefore shows on the outputs right after that edge: one cycle for a reset, a parallel write, a serial bit or a read-back, and a complete serial load shows after its 2*OFS_W-th enabled edge. The bench drives inputs just after a falling edge and holds them across exactly one rising edge. It compares the outputs at the following falling edge, so each check lands in the cycle the result is due and never at the edge where the result changes. Checks that a stimulus is ignored read the offsets directly after the ignored edge, before any other stimulus.

// File: rtl/fofs_pkg.sv
package fofs_pkg;
  // Which offset register a sequence position refers to
  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } ofs_sel_e;
endpackage

// File: rtl/fofs_seq_ptr.sv
// Two-entry sequence position: empty offset first, then full, then wrap
module fofs_seq_ptr
  import fofs_pkg::*;
(
  input  logic     clk,
  input  logic     clr,
  input  logic     adv,
  output ofs_sel_e sel
);
  always_ff @(posedge clk) begin
    if (clr)      sel <= SEL_EMPTY;
    else if (adv) sel <= (sel == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  end

  // R4 / R8: each access moves to the other register
  p_ptr_toggle_r4: assert property (@(posedge clk) disable iff (clr)
    (!clr && adv) |=> (sel != $past(sel)));
  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (clr)
    (!clr && !adv) |=> $stable(sel));
endmodule

// File: rtl/fofs_ser_cnt.sv
// Bit position for serial loading, wrapping after TOTAL bits
module fofs_ser_cnt #(
  parameter int TOTAL = 28,
  localparam int IW = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          adv,
  output logic [IW-1:0] idx
);
  localparam logic [IW-1:0] LAST = IW'(TOTAL - 1);

  always_ff @(posedge clk) begin
    if (clr)           idx <= '0;
    else if (adv) begin
      if (idx == LAST) idx <= '0;
      else             idx <= idx + 1'b1;
    end
  end

  p_idx_range_r6: assert property (@(posedge clk) disable iff (clr)
    idx <= LAST);
  p_idx_wrap_r6: assert property (@(posedge clk) disable iff (clr)
    (!clr && adv && idx == LAST) |=> (idx == '0));
endmodule

// File: rtl/fofs_prog.sv
module fofs_prog
  import fofs_pkg::*;
#(
  parameter int OFS_W  = 14,
  parameter int BUS_W  = 18,
  parameter int DEF_LO = 127,
  parameter int DEF_HI = 1023
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             prst,
  input  logic             cfg_sel,
  input  logic             ser_in,
  input  logic             ser_en,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [BUS_W-1:0] din,
  output logic [BUS_W-1:0] dout,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs,
  output logic             ser_mode,
  output logic             ft_mode
);
  localparam int TOTAL_BITS = 2 * OFS_W;
  localparam int IW         = $clog2(TOTAL_BITS);
  localparam logic [OFS_W-1:0] LO_VAL = OFS_W'(DEF_LO);
  localparam logic [OFS_W-1:0] HI_VAL = OFS_W'(DEF_HI);

  logic             seq_clr;
  logic             par_wr, ser_wr, ofs_rd;
  logic [OFS_W-1:0] wr_val;
  ofs_sel_e         wsel, rsel;
  logic [IW-1:0]    bit_idx;

  // Sequence positions restart on either reset
  assign seq_clr = rst | prst;
  // Offset access only while steering is selected (ser_en needs no steering)
  assign par_wr  = !seq_clr && cfg_sel && wr_en && !ser_mode;
  assign ser_wr  = !seq_clr && ser_en && ser_mode;
  assign ofs_rd  = !seq_clr && cfg_sel && rd_en;
  // Saturate when the bus word exceeds the offset range
  assign wr_val  = (|din[BUS_W-1:OFS_W]) ? '1 : din[OFS_W-1:0];

  fofs_seq_ptr u_wptr (.clk(clk), .clr(seq_clr), .adv(par_wr), .sel(wsel));
  fofs_seq_ptr u_rptr (.clk(clk), .clr(seq_clr), .adv(ofs_rd), .sel(rsel));

  fofs_ser_cnt #(.TOTAL(TOTAL_BITS)) u_scnt (
    .clk(clk), .clr(seq_clr), .adv(ser_wr), .idx(bit_idx)
  );

  // Offsets and latched configuration
  always_ff @(posedge clk) begin
    if (rst) begin
      empty_ofs <= cfg_sel ? HI_VAL : LO_VAL;
      full_ofs  <= cfg_sel ? HI_VAL : LO_VAL;
      ser_mode  <= cfg_sel;
      ft_mode   <= ser_in;
    end else if (par_wr) begin
      if (wsel == SEL_EMPTY) empty_ofs <= wr_val;
      else                   full_ofs  <= wr_val;
    end else if (ser_wr) begin
      for (int b = 0; b < OFS_W; b++) begin
        if (int'(bit_idx) == b)         empty_ofs[b] <= ser_in;
        if (int'(bit_idx) == b + OFS_W) full_ofs[b]  <= ser_in;
      end
    end
  end

  // Read-back register
  always_ff @(posedge clk) begin
    if (seq_clr)     dout <= '0;
    else if (ofs_rd) dout <= {{(BUS_W-OFS_W){1'b0}},
                              (rsel == SEL_EMPTY) ? empty_ofs : full_ofs};
  end

  // R1 / R2 / R3 / R10: master reset loads defaults and latches config
  p_def_load_r1: assert property (@(posedge clk)
    rst |=> (empty_ofs == ($past(cfg_sel) ? HI_VAL : LO_VAL)) &&
            (full_ofs == empty_ofs));
  p_method_latch_r2: assert property (@(posedge clk)
    rst |=> (ser_mode == $past(cfg_sel)));
  p_ft_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(ft_mode));
  p_dout_clear_r10: assert property (@(posedge clk)
    rst |=> (dout == '0));
  // R5 / R7: offsets move only on an access of the selected method
  p_par_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (!ser_mode && !(cfg_sel && wr_en)) |=>
      ($stable(empty_ofs) && $stable(full_ofs)));
  p_ser_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (ser_mode && !ser_en) |=> ($stable(empty_ofs) && $stable(full_ofs)));
  // R8: read-back bus holds between reads
  p_dout_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!prst && !(cfg_sel && rd_en)) |=> $stable(dout));
  // R9: partial reset keeps offsets and configuration
  p_prst_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (prst && !rst) |=> ($stable(empty_ofs) && $stable(full_ofs) &&
                        $stable(ser_mode) && $stable(ft_mode) && dout == '0));
endmodule

// File: tb/fofs_prog_tb.sv
module fofs_prog_tb;
  localparam int OFS_W = 14;
  localparam int BUS_W = 18;

  logic             clk = 1'b0;
  logic             rst = 1'b1, prst = 1'b0, cfg_sel = 1'b0, ser_in = 1'b0;
  logic             ser_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [BUS_W-1:0] din = '0;
  logic [BUS_W-1:0] dout;
  logic [OFS_W-1:0] empty_ofs, full_ofs;
  logic             ser_mode, ft_mode;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  fofs_prog #(.OFS_W(OFS_W), .BUS_W(BUS_W)) u_dut (
    .clk(clk), .rst(rst), .prst(prst), .cfg_sel(cfg_sel), .ser_in(ser_in),
    .ser_en(ser_en), .wr_en(wr_en), .rd_en(rd_en), .din(din), .dout(dout),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs), .ser_mode(ser_mode),
    .ft_mode(ft_mode)
  );

  always #4 clk = ~clk;  // 125 MHz

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic mrst(logic sel, logic si);
    rst = 1'b1; cfg_sel = sel; ser_in = si;
    tick(); tick();
    rst = 1'b0; cfg_sel = 1'b0; ser_in = 1'b0;
  endtask

  task automatic pwrite(logic [BUS_W-1:0] v, logic steer);
    cfg_sel = steer; wr_en = 1'b1; din = v;
    tick();
    cfg_sel = 1'b0; wr_en = 1'b0; din = '0;
  endtask

  task automatic sbit(logic b);
    ser_en = 1'b1; ser_in = b;
    tick();
    ser_en = 1'b0; ser_in = 1'b0;
  endtask

  task automatic pread();
    cfg_sel = 1'b1; rd_en = 1'b1;
    tick();
    cfg_sel = 1'b0; rd_en = 1'b0;
  endtask

  task automatic do_prst();
    prst = 1'b1;
    tick();
    prst = 1'b0;
  endtask

  task automatic sload(int e, int f);
    for (int i = 0; i < 2 * OFS_W; i++)
      sbit(i < OFS_W ? e[i] : f[i - OFS_W]);
  endtask

  // Reset with cfg_sel low: defaults 127, parallel, mode bit captured
  task automatic t_reset_low();
    mrst(1'b0, 1'b1);
    chk("R1 empty default", int'(empty_ofs), 127);
    chk("R1 full default", int'(full_ofs), 127);
    chk("R2 parallel method", int'(ser_mode), 0);
    chk("R3 mode bit", int'(ft_mode), 1);
    chk("R10 dout cleared", int'(dout), 0);
    ser_in = 1'b0; tick(); tick();
    chk("R3 mode bit held", int'(ft_mode), 1);
  endtask

  task automatic t_parallel();
    pwrite(18'd300, 1'b1);
    chk("R4 first write to empty", int'(empty_ofs), 300);
    chk("R4 full untouched", int'(full_ofs), 127);
    pwrite(18'd500, 1'b1);
    chk("R4 second write to full", int'(full_ofs), 500);
    pwrite(18'h20005, 1'b1);
    chk("R4 wrap and saturate", int'(empty_ofs), 16383);
    pwrite(18'd9, 1'b0);
    chk("R5 unsteered write empty", int'(empty_ofs), 16383);
    chk("R5 unsteered write full", int'(full_ofs), 500);
    sbit(1'b0);
    chk("R7 ser_en ignored in parallel", int'(empty_ofs), 16383);
    pwrite(18'd42, 1'b1);
    chk("R4 sequence continues to full", int'(full_ofs), 42);
  endtask

  task automatic t_readback();
    pread();
    chk("R8 read empty first", int'(dout), 16383);
    tick();
    chk("R8 dout held", int'(dout), 16383);
    pread();
    chk("R8 read full second", int'(dout), 42);
    pread();
    chk("R8 read wraps", int'(dout), 16383);
  endtask

  task automatic t_partial();
    pwrite(18'd11, 1'b1);          // write sequence now at full
    do_prst();
    chk("R9 dout cleared", int'(dout), 0);
    chk("R9 empty kept", int'(empty_ofs), 11);
    chk("R9 full kept", int'(full_ofs), 42);
    chk("R9 method kept", int'(ser_mode), 0);
    chk("R9 mode bit kept", int'(ft_mode), 1);
    pwrite(18'd77, 1'b1);
    chk("R9 write restarts at empty", int'(empty_ofs), 77);
    chk("R9 full unchanged", int'(full_ofs), 42);
    pread();
    chk("R9 read restarts at empty", int'(dout), 77);
  endtask

  task automatic t_serial();
    mrst(1'b1, 1'b0);
    chk("R1 empty high default", int'(empty_ofs), 1023);
    chk("R1 full high default", int'(full_ofs), 1023);
    chk("R2 serial method", int'(ser_mode), 1);
    chk("R3 mode bit low", int'(ft_mode), 0);
    pwrite(18'd5, 1'b1);
    chk("R7 parallel ignored in serial", int'(empty_ofs), 1023);
    sload(14'h1A5C, 14'h0333);
    chk("R6 empty serial load", int'(empty_ofs), 'h1A5C);
    chk("R6 full serial load", int'(full_ofs), 'h0333);
    for (int i = 0; i < 5; i++) sbit(1'b1);
    chk("R6 wrap writes empty bits", int'(empty_ofs), 'h1A5F);
    do_prst();
    sload(14'h0123, 14'h2F0F);
    chk("R9 serial restarts empty", int'(empty_ofs), 'h0123);
    chk("R9 serial restarts full", int'(full_ofs), 'h2F0F);
    pread(); pread();
    chk("R8 read in serial mode", int'(dout), 'h2F0F);
  endtask

  initial begin
    t_reset_low();
    t_parallel();
    t_readback();
    t_partial();
    t_serial();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule